// File: doc/BRIEF.md
# Dual-Direction Timestamp Capture Queue

This block stores packet timestamps for two directions, receive and transmit, each in its own small queue. A capture strobe from the frame path pushes one entry holding a 48-bit seconds value, a 30-bit nanoseconds value and a 16-bit message sequence identifier. Software drains each queue through a 16-bit register port by reading the words of the head entry, ending with the sequence word, which advances the queue.

Alongside the queues sit an occupancy register, a four-bit interrupt status that clears when read, an enable mask that gates the interrupt output, and a hard-reset command that empties both queues and clears status while keeping the mask. A push into a full queue is dropped and flagged as an overflow.

Top module: `tstamp_queue`

## Requirements
- R1: After reset both queues are empty, the occupancy and status registers read 0, the receive nanosecond-high word reads 0 and `irq_o` is 0.
- R2: A captured entry is read through six words, receive at addresses 0..5 and transmit at 8..13: word 0 = {valid in bit 15, 0 in bit 14, ns[29:16]}, word 1 = ns[15:0], word 2 = sec[47:32], word 3 = sec[31:16], word 4 = sec[15:0], word 5 = sequence identifier.
- R3: Entries leave in push order; only a read of word 5 removes the head entry, reads of words 0..4 leave the queue unchanged.
- R4: Address 6 returns the receive entry count in bits 7:0 and the transmit entry count in bits 15:8.
- R5: With a queue empty, all six of its words read 0 (valid flag 0) and a word-5 read does not change its count.
- R6: A push into a full queue (DEPTH entries) is dropped, leaves the stored entries and count unchanged, and sets that direction's overflow bit.
- R7: Address 7 returns status bit 0 receive-available, bit 1 transmit-available, bit 2 receive-overflow, bit 3 transmit-overflow; a read clears all four; an available bit is set by an accepted push and set again one cycle after a clearing read while its queue still holds entries; an event in the cycle of the read is kept.
- R8: Address 14 holds a four-bit enable mask in bits 3:0, readable back; `irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R9: A write to address 15 with bit 0 set empties both queues and clears all status bits in the next cycle, keeping the enable mask and dropping a push in that cycle; with bit 0 clear the write has no effect.
- R10: The two directions are independent: pushes, reads and overflow of one never change the other's count, contents or status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_cap_i | input | 1 | Receive capture strobe |
| rx_sec_i | input | 48 | Receive capture seconds |
| rx_ns_i | input | 30 | Receive capture nanoseconds |
| rx_seq_i | input | 16 | Receive message sequence identifier |
| tx_cap_i | input | 1 | Transmit capture strobe |
| tx_sec_i | input | 48 | Transmit capture seconds |
| tx_ns_i | input | 30 | Transmit capture nanoseconds |
| tx_seq_i | input | 16 | Transmit message sequence identifier |
| reg_addr_i | input | 4 | Register word address |
| reg_rd_i | input | 1 | Register read strobe, side effects at the clock edge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational while reg_rd_i is high |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions guard per-cycle invariants: counts never exceed the depth, a full queue ignores a lone push, a sequence-word read drops the count by one and an empty-queue read does not, overflow bits hold until a read or hard reset, and a hard reset leaves queues and status clear. Only the bench's scenarios show entry contents and field positions, first-in-first-out order across overflow, the clear-then-reassert rhythm of back-to-back status reads, and the independence of the two directions under mixed random traffic.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int SEC_W = 48;
  localparam int NS_W  = 30;
  localparam int SEQ_W = 16;
  localparam int REG_W = 16;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [SEQ_W-1:0] seq;
  } tsq_entry_t;

  // word index within a direction; bit 3 of the address picks the direction
  localparam logic [2:0] W_NSH = 3'd0;
  localparam logic [2:0] W_NSL = 3'd1;
  localparam logic [2:0] W_SH  = 3'd2;
  localparam logic [2:0] W_SM  = 3'd3;
  localparam logic [2:0] W_SL  = 3'd4;
  localparam logic [2:0] W_HDR = 3'd5;

  localparam logic [3:0] A_CNT  = 4'd6;
  localparam logic [3:0] A_STS  = 4'd7;
  localparam logic [3:0] A_EN   = 4'd14;
  localparam logic [3:0] A_HRST = 4'd15;
endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo
  import tsq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  tsq_entry_t       data_i,
  input  logic             pop_i,
  output tsq_entry_t       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  tsq_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  p_full_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (count_o == $past(count_o)));
  p_pop_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o && !flush_i) |=> (count_o == $past(count_o) - 1'b1));
  p_empty_nopop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/tsq_irq_status.sv
module tsq_irq_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       clr_i,
  input  logic [1:0] nonempty_i,
  input  logic [1:0] push_ok_i,
  input  logic [1:0] ovf_ev_i,
  output logic [3:0] sts_o
);
  logic [3:0] sts_q, sts_d;

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      sts_d[d]   = (sts_q[d] & ~clr_i) | push_ok_i[d] | (nonempty_i[d] & ~clr_i);
      sts_d[2+d] = (sts_q[2+d] & ~clr_i) | ovf_ev_i[d];
    end
    if (flush_i) sts_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  p_ovf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[2] && !clr_i && !flush_i) |=> sts_o[2]);
  p_ovf_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ovf_ev_i == 2'b00) |=> (sts_o[3:2] == 2'b00));
  p_hard_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (sts_o == 4'b0000));
endmodule

// File: rtl/tstamp_queue.sv
module tstamp_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_cap_i,
  input  logic [47:0] rx_sec_i,
  input  logic [29:0] rx_ns_i,
  input  logic [15:0] rx_seq_i,
  input  logic        tx_cap_i,
  input  logic [47:0] tx_sec_i,
  input  logic [29:0] tx_ns_i,
  input  logic [15:0] tx_seq_i,
  input  logic [3:0]  reg_addr_i,
  input  logic        reg_rd_i,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o
);
  tsq_entry_t       din  [2];
  tsq_entry_t       head [2];
  logic [CNT_W-1:0] cnt  [2];
  logic [1:0]       cap, pop, empty, full, push_ok, ovf_ev;
  logic [3:0]       sts, en_q;
  logic             flush, clr;

  assign cap[0] = rx_cap_i;
  assign cap[1] = tx_cap_i;
  assign din[0] = '{sec: rx_sec_i, ns: rx_ns_i, seq: rx_seq_i};
  assign din[1] = '{sec: tx_sec_i, ns: tx_ns_i, seq: tx_seq_i};

  assign flush = reg_wr_i && (reg_addr_i == A_HRST) && reg_wdata_i[0];
  assign clr   = reg_rd_i && (reg_addr_i == A_STS);

  for (genvar d = 0; d < 2; d++) begin : g_dir
    assign pop[d]     = reg_rd_i && (reg_addr_i == {d[0], W_HDR});
    assign push_ok[d] = cap[d] & ~full[d] & ~flush;
    assign ovf_ev[d]  = cap[d] & full[d] & ~flush;

    tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush),
      .push_i  (cap[d]),
      .data_i  (din[d]),
      .pop_i   (pop[d]),
      .head_o  (head[d]),
      .count_o (cnt[d]),
      .empty_o (empty[d]),
      .full_o  (full[d])
    );
  end

  tsq_irq_status u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .clr_i      (clr),
    .nonempty_i (~empty),
    .push_ok_i  (push_ok),
    .ovf_ev_i   (ovf_ev),
    .sts_o      (sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  en_q <= '0;
    else if (reg_wr_i && reg_addr_i == A_EN)      en_q <= reg_wdata_i[3:0];
  end

  assign irq_o = |(sts & en_q);

  always_comb begin
    tsq_entry_t hd;
    logic       dsel;
    dsel        = reg_addr_i[3];
    hd          = head[dsel];
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (reg_addr_i == A_CNT)       reg_rdata_o = {8'(cnt[1]), 8'(cnt[0])};
      else if (reg_addr_i == A_STS)  reg_rdata_o = {12'b0, sts};
      else if (reg_addr_i == A_EN)   reg_rdata_o = {12'b0, en_q};
      else if (!empty[dsel]) begin
        case (reg_addr_i[2:0])
          W_NSH:   reg_rdata_o = {1'b1, 1'b0, hd.ns[29:16]};
          W_NSL:   reg_rdata_o = hd.ns[15:0];
          W_SH:    reg_rdata_o = hd.sec[47:32];
          W_SM:    reg_rdata_o = hd.sec[31:16];
          W_SL:    reg_rdata_o = hd.sec[15:0];
          W_HDR:   reg_rdata_o = hd.seq;
          default: reg_rdata_o = '0;
        endcase
      end
    end
  end

  p_empty_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == {1'b0, W_NSH} && empty[0]) |-> (reg_rdata_o[15] == 1'b0));
  p_dir_indep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap[1] && !pop[1] && !flush) |=> (cnt[1] == $past(cnt[1])));
endmodule

// File: tb/sim_tstamp_queue.sv
`timescale 1ns/1ps
module sim_tstamp_queue;
  localparam int DEPTH = 4;

  logic        clk = 0, rst_ni = 0;
  logic        rx_cap = 0, tx_cap = 0, reg_rd = 0, reg_wr = 0;
  logic [47:0] rx_sec = 0, tx_sec = 0;
  logic [29:0] rx_ns = 0, tx_ns = 0;
  logic [15:0] rx_seq = 0, tx_seq = 0, wdata = 0, rdata;
  logic [3:0]  addr = 0;
  logic        irq;

  always #2 clk = ~clk;

  tstamp_queue #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_cap_i(rx_cap), .rx_sec_i(rx_sec), .rx_ns_i(rx_ns), .rx_seq_i(rx_seq),
    .tx_cap_i(tx_cap), .tx_sec_i(tx_sec), .tx_ns_i(tx_ns), .tx_seq_i(tx_seq),
    .reg_addr_i(addr), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  int checks = 0, errors = 0;

  // model
  logic [47:0] m_sec [2][DEPTH];
  logic [29:0] m_ns  [2][DEPTH];
  logic [15:0] m_seq [2][DEPTH];
  int          m_cnt [2];
  logic [1:0]  m_av, m_ov;
  logic [3:0]  m_en;
  // data driven on the next capture
  logic [47:0] d_sec [2];
  logic [29:0] d_ns  [2];
  logic [15:0] d_seq [2];

  function automatic logic [15:0] exp_rd(logic [3:0] a);
    int d, w;
    if (a == 4'd6)  return {8'(m_cnt[1]), 8'(m_cnt[0])};
    if (a == 4'd7)  return {12'b0, m_ov[1], m_ov[0], m_av[1], m_av[0]};
    if (a == 4'd14) return {12'b0, m_en};
    if (a == 4'd15) return 16'h0;
    d = int'(a[3]); w = int'(a[2:0]);
    if (m_cnt[d] == 0) return 16'h0;
    case (w)
      0: return {2'b10, m_ns[d][0][29:16]};
      1: return m_ns[d][0][15:0];
      2: return m_sec[d][0][47:32];
      3: return m_sec[d][0][31:16];
      4: return m_sec[d][0][15:0];
      5: return m_seq[d][0];
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: drive, sample, then advance the model across the edge
  task automatic cyc(logic rc, logic tc, logic rd, logic wr, logic [3:0] a,
                     logic [15:0] wd, string tag);
    logic flush, clr;
    @(negedge clk);
    rx_cap = rc; tx_cap = tc; reg_rd = rd; reg_wr = wr; addr = a; wdata = wd;
    rx_sec = d_sec[0]; rx_ns = d_ns[0]; rx_seq = d_seq[0];
    tx_sec = d_sec[1]; tx_ns = d_ns[1]; tx_seq = d_seq[1];
    #1;
    if (rd) check(tag, rdata, exp_rd(a));
    check("R8 irq", {15'b0, irq}, {15'b0, |({m_ov, m_av} & m_en)});
    flush = wr && a == 4'd15 && wd[0];
    clr   = rd && a == 4'd7;
    for (int d = 0; d < 2; d++) begin
      logic cap_d, pop_d, pok, oev;
      int   c0;
      c0    = m_cnt[d];
      cap_d = (d == 0) ? rc : tc;
      pop_d = rd && a == {d[0], 3'd5} && c0 > 0;
      pok   = cap_d && c0 < DEPTH && !flush;
      oev   = cap_d && c0 == DEPTH && !flush;
      if (flush) begin
        m_cnt[d] = 0; m_av[d] = 0; m_ov[d] = 0;
      end else begin
        m_av[d] = (m_av[d] && !clr) || pok || (c0 > 0 && !clr);
        m_ov[d] = (m_ov[d] && !clr) || oev;
        if (pop_d) begin
          for (int i = 0; i < DEPTH - 1; i++) begin
            m_sec[d][i] = m_sec[d][i+1]; m_ns[d][i] = m_ns[d][i+1]; m_seq[d][i] = m_seq[d][i+1];
          end
          m_cnt[d]--;
        end
        if (pok) begin
          m_sec[d][m_cnt[d]] = d_sec[d]; m_ns[d][m_cnt[d]] = d_ns[d]; m_seq[d][m_cnt[d]] = d_seq[d];
          m_cnt[d]++;
        end
      end
    end
    if (wr && a == 4'd14) m_en = wd[3:0];
  endtask

  task automatic rand_data();
    for (int d = 0; d < 2; d++) begin
      d_sec[d] = {16'($urandom), $urandom};
      d_ns[d]  = 30'($urandom);
      d_seq[d] = 16'($urandom);
    end
  endtask

  function automatic string tag_of(logic [3:0] a);
    if (a == 4'd6) return "R4";
    if (a == 4'd7) return "R7";
    if (a[2:0] == 3'd5) return "R3";
    return "R2";
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_cnt[0] = 0; m_cnt[1] = 0; m_av = 0; m_ov = 0; m_en = 0;
    for (int d = 0; d < 2; d++) begin d_sec[d] = 0; d_ns[d] = 0; d_seq[d] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    cyc(0, 0, 1, 0, 4'd6, 0, "R1 count");
    cyc(0, 0, 1, 0, 4'd7, 0, "R1 status");
    cyc(0, 0, 1, 0, 4'd0, 0, "R1 nshi");
    // R5 empty reads
    cyc(0, 0, 1, 0, 4'd5, 0, "R5 empty hdr");
    cyc(0, 0, 1, 0, 4'd13, 0, "R5 empty tx hdr");
    cyc(0, 0, 1, 0, 4'd6, 0, "R5 count after empty hdr");
    // R8 enable all
    cyc(0, 0, 0, 1, 4'd14, 16'h000F, "R8");
    cyc(0, 0, 1, 0, 4'd14, 0, "R8 enable readback");
    // R2 word layout
    d_sec[0] = 48'h1234_5678_9ABC; d_ns[0] = 30'h2345_6789; d_seq[0] = 16'hBEEF;
    cyc(1, 0, 0, 0, 0, 0, "R2");
    for (int w = 0; w < 5; w++) cyc(0, 0, 1, 0, 4'(w), 0, "R2 word");
    cyc(0, 0, 1, 0, 4'd6, 0, "R3 no pop on data words");
    cyc(0, 0, 1, 0, 4'd7, 0, "R7 rx avail");
    cyc(0, 0, 1, 0, 4'd5, 0, "R3 hdr pop");
    cyc(0, 0, 1, 0, 4'd0, 0, "R5 drained valid 0");
    cyc(0, 0, 1, 0, 4'd7, 0, "R7 clear after drain");
    // R6 overflow: five pushes, fifth dropped
    for (int k = 0; k < 5; k++) begin
      d_seq[0] = 16'h100 + 16'(k); d_ns[0] = 30'(k * 7); d_sec[0] = 48'(k);
      cyc(1, 0, 0, 0, 0, 0, "R6");
    end
    cyc(0, 0, 1, 0, 4'd6, 0, "R6 count at depth");
    cyc(0, 0, 1, 0, 4'd7, 0, "R6 overflow bit");
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 0, 4'd5, 0, "R6 order kept");
    cyc(0, 0, 1, 0, 4'd6, 0, "R6 drained");
    // R7 back-to-back status reads, R10 transmit only
    d_seq[1] = 16'hA5A5; d_ns[1] = 30'h3FFF_FFFF; d_sec[1] = 48'hFFFF_0000_FFFF;
    cyc(0, 1, 0, 0, 0, 0, "R10");
    cyc(0, 1, 0, 0, 0, 0, "R10");
    cyc(0, 0, 1, 0, 4'd7, 0, "R7 first read");
    cyc(0, 0, 1, 0, 4'd7, 0, "R7 second read");
    cyc(0, 0, 0, 0, 0, 0, "idle");
    cyc(0, 0, 1, 0, 4'd7, 0, "R7 reasserted");
    cyc(0, 0, 1, 0, 4'd6, 0, "R10 counts");
    cyc(0, 0, 1, 0, 4'd8, 0, "R10 tx nshi");
    cyc(0, 0, 1, 0, 4'd0, 0, "R10 rx still empty");
    // R7 event in the read cycle is kept
    cyc(1, 0, 1, 0, 4'd7, 0, "R7 read with push");
    cyc(0, 0, 1, 0, 4'd7, 0, "R7 push kept");
    // R9 hard reset
    cyc(0, 0, 0, 1, 4'd15, 16'h0000, "R9 no effect");
    cyc(0, 0, 1, 0, 4'd6, 0, "R9 bit0 clear keeps queues");
    cyc(1, 0, 0, 1, 4'd15, 16'h0001, "R9 hard reset");
    cyc(0, 0, 1, 0, 4'd6, 0, "R9 queues empty");
    cyc(0, 0, 1, 0, 4'd7, 0, "R9 status clear");
    cyc(0, 0, 1, 0, 4'd14, 0, "R9 enable kept");
    // R8 masking
    cyc(0, 0, 0, 1, 4'd14, 16'h0001, "R8");
    cyc(0, 1, 0, 0, 0, 0, "R8 masked tx");
    cyc(0, 0, 0, 0, 0, 0, "R8 irq low");
    cyc(1, 0, 0, 0, 0, 0, "R8 rx");
    cyc(0, 0, 0, 0, 0, 0, "R8 irq high");
    cyc(0, 0, 0, 1, 4'd14, 16'h000F, "R8");

    // mixed random traffic
    for (int it = 0; it < 1500; it++) begin
      int r;
      logic [3:0] a;
      rand_data();
      r = $urandom % 10;
      a = 4'($urandom % 16);
      if ($urandom % 80 == 0) cyc(0, 0, 0, 1, 4'd15, 16'h0001, "R9");
      else if (r < 3) cyc(1, 0, 0, 0, 0, 0, "R6");
      else if (r < 5) cyc(0, 1, 0, 0, 0, 0, "R10");
      else if (r == 5) cyc(1, 1, 0, 0, 0, 0, "R10");
      else if (r == 6) cyc($urandom % 2 == 1, 0, 1, 0, a, 0, tag_of(a));
      else if (r == 7) cyc(0, $urandom % 2 == 1, 1, 0, 4'd7, 0, "R7");
      else if (r == 8) cyc(0, 0, 1, 0, 4'd6, 0, "R4");
      else cyc(0, 0, 1, 0, ($urandom % 2 == 1) ? 4'd13 : 4'd5, 0, "R3");
    end
    @(negedge clk);
    rx_cap = 0; tx_cap = 0; reg_rd = 0; reg_wr = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule